// File: doc/BRIEF.md
# Debug Instruction Injection Buffer

This block sits on the debug side of a processor core. While the core is halted, an external debug master writes the bytes of one instruction, at most five of them, into a small set of write-only byte registers. Writing the register that holds the leading opcode, called the trigger byte, releases the core for exactly one instruction. The core then pulls the buffered bytes through a fetch port by index, starting with the trigger byte. When the core reports that the instruction has retired, the block asks it to halt again.

The debug write port takes one byte per strobe. A start flag loads the target address. Each later strobe without the flag writes to the address after the previous one, so one burst can load a whole instruction. The trigger byte has the highest address of the group, and the other bytes sit below it in reverse fetch order. A burst that begins at the lowest address and rises through the group therefore fills the operand bytes first and ends on the trigger. The register contents are undefined after reset. Bytes that the instruction does not fetch need not be written. An instruction longer than five bytes cannot be injected.

Top module: `dbg_inject_buf`

## Requirements
- R1: Write address 25h minus k stores byte k, for k from 0 to 4 (21h holds byte 4 and 25h holds byte 0). A write to any other address changes no byte.
- R2: A strobe with `dbg_wr_start` high writes to `dbg_wr_addr`. A strobe with it low writes to the previous strobe's address plus one, wrapping at 8 bits. The address pointer is 00h after reset.
- R3: A write to 25h while idle makes `step_pulse` high for exactly one cycle, the cycle after the write. `busy` goes high in that same cycle.
- R4: With `fetch_idx` = k in the range 0 to 4, `fetch_data` shows byte k in the same cycle. Byte 0 is the first opcode.
- R5: While `busy` is high, writes to 21h through 24h are ignored.
- R6: A write to 25h while `busy` is high is rejected. Byte 0 keeps its value, no `step_pulse` follows, and `inj_err` is set in the next cycle.
- R7: With `fetch_idx` at 5 or more, `fetch_data` shows the no-operation byte 00h. If `fetch_req` and `busy` are also high, `inj_err` is set in the next cycle.
- R8: `core_retire` while `busy` is high clears `busy` and raises `rebreak_req` for exactly one cycle, the next cycle. `core_retire` while idle has no effect.
- R9: `inj_err` stays set until a cycle with `dbg_err_clr` high. In a cycle where a new error and a clear coincide, the error wins.
- R10: While reset is asserted and right after it, `step_pulse`, `rebreak_req`, `busy` and `inj_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_wr_en | input | 1 | Debug byte write strobe |
| dbg_wr_start | input | 1 | Start of burst: use dbg_wr_addr as the address of this write |
| dbg_wr_addr | input | 8 | Burst start address |
| dbg_wr_data | input | 8 | Byte written |
| dbg_err_clr | input | 1 | Clears the sticky error flag |
| core_retire | input | 1 | Core reports that the injected instruction has retired |
| fetch_req | input | 1 | Core is fetching an injected byte |
| fetch_idx | input | 3 | Index of the byte fetched, 0 first |
| fetch_data | output | 8 | Byte at fetch_idx, or 00h beyond byte 4 |
| step_pulse | output | 1 | One-cycle request to leave break and run one instruction |
| rebreak_req | output | 1 | One-cycle request to return to break |
| busy | output | 1 | An injected instruction is executing |
| inj_err | output | 1 | Sticky error: rejected trigger or over-long fetch |

## Verification
The assertions assume the core raises `core_retire` only after it has seen `step_pulse`, and that it fetches only while `busy` is high. They also assume the debug master performs at most one write per cycle and starts every burst with `dbg_wr_start`. The stimulus follows these rules: it retires each instruction once, after its fetches, and every fetch outside the over-long case stays within the bytes actually written. The rejected-trigger, ignored-write and over-long-fetch cases are issued on purpose while an instruction is in flight. The effect of each is then checked through the fetch port and the error flag.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;
  typedef enum logic {
    ST_HALT = 1'b0,
    ST_BUSY = 1'b1
  } inj_state_e;
endpackage

// File: rtl/inj_wr_decode.sv
module inj_wr_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_BYTES = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_start,
  input  logic [ADDR_W-1:0]    wr_addr,
  output logic [NUM_BYTES-1:0] slot_hit
);
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] eff_addr;

  // Window test done one bit wider so base + count cannot wrap.
  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    logic [ADDR_W:0] lo, hi;
    lo = {1'b0, BASE_ADDR};
    hi = lo + (ADDR_W+1)'(NUM_BYTES);
    return ({1'b0, a} >= lo) && ({1'b0, a} < hi);
  endfunction

  // Byte index held at an address: highest address is byte 0.
  function automatic logic [ADDR_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return ADDR_W'(NUM_BYTES - 1) - (a - BASE_ADDR);
  endfunction

  assign eff_addr = wr_start ? wr_addr : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr_q <= '0;
    else if (wr_en) ptr_q <= eff_addr + ADDR_W'(1);
  end

  for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_hit
    assign slot_hit[gi] = wr_en && in_window(eff_addr) &&
                          (slot_of(eff_addr) == ADDR_W'(gi));
  end
endmodule

// File: rtl/inj_byte_store.sv
module inj_byte_store #(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 5,
  parameter int IDX_W     = 3,
  parameter logic [DATA_W-1:0] NOP_BYTE = 8'h00
) (
  input  logic                 clk,
  input  logic [NUM_BYTES-1:0] wr_mask,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [DATA_W-1:0]    rd_data
);
  logic [DATA_W-1:0] mem [NUM_BYTES];

  // No reset: contents are undefined until written.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BYTES; i++)
      if (wr_mask[i]) mem[i] <= wr_data;
  end

  always_comb begin
    rd_data = NOP_BYTE;
    for (int i = 0; i < NUM_BYTES; i++)
      if (rd_idx == IDX_W'(i)) rd_data = mem[i];
  end
endmodule

// File: rtl/inj_step_ctrl.sv
module inj_step_ctrl
  import dbg_inject_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_wr,
  input  logic retire,
  input  logic fetch_ovf,
  input  logic err_clr,
  output logic trig_accept,
  output logic step_pulse,
  output logic rebreak_req,
  output logic busy,
  output logic err
);
  inj_state_e state_q;
  logic       trig_reject;

  assign busy        = (state_q == ST_BUSY);
  assign trig_accept = trig_wr && !busy;
  assign trig_reject = trig_wr && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_HALT;
      step_pulse  <= 1'b0;
      rebreak_req <= 1'b0;
      err         <= 1'b0;
    end else begin
      step_pulse  <= trig_accept;
      rebreak_req <= busy && retire;
      err         <= (err && !err_clr) || trig_reject || fetch_ovf;
      case (state_q)
        ST_HALT: if (trig_accept) state_q <= ST_BUSY;
        ST_BUSY: if (retire)      state_q <= ST_HALT;
        default: state_q <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/dbg_inject_buf.sv
module dbg_inject_buf #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h21,
  parameter logic [DATA_W-1:0] NOP_BYTE  = 8'h00,
  localparam int IDX_W = $clog2(NUM_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_wr_en,
  input  logic              dbg_wr_start,
  input  logic [ADDR_W-1:0] dbg_wr_addr,
  input  logic [DATA_W-1:0] dbg_wr_data,
  input  logic              dbg_err_clr,
  input  logic              core_retire,
  input  logic              fetch_req,
  input  logic [IDX_W-1:0]  fetch_idx,
  output logic [DATA_W-1:0] fetch_data,
  output logic              step_pulse,
  output logic              rebreak_req,
  output logic              busy,
  output logic              inj_err
);
  logic [NUM_BYTES-1:0] slot_hit;
  logic [NUM_BYTES-1:0] wr_mask;
  logic                 trig_wr;
  logic                 trig_accept;
  logic                 fetch_ovf;

  inj_wr_decode #(
    .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(dbg_wr_en), .wr_start(dbg_wr_start),
    .wr_addr(dbg_wr_addr), .slot_hit(slot_hit)
  );

  assign trig_wr   = slot_hit[0];
  assign fetch_ovf = fetch_req && busy && (fetch_idx >= IDX_W'(NUM_BYTES));

  // Trigger byte only when accepted; operand bytes frozen while busy.
  for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_mask
    if (gi == 0) begin : g_trig
      assign wr_mask[gi] = slot_hit[gi] && trig_accept;
    end else begin : g_oper
      assign wr_mask[gi] = slot_hit[gi] && !busy;
    end
  end

  inj_byte_store #(
    .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W), .NOP_BYTE(NOP_BYTE)
  ) u_store (
    .clk(clk), .wr_mask(wr_mask), .wr_data(dbg_wr_data),
    .rd_idx(fetch_idx), .rd_data(fetch_data)
  );

  inj_step_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .retire(core_retire),
    .fetch_ovf(fetch_ovf), .err_clr(dbg_err_clr), .trig_accept(trig_accept),
    .step_pulse(step_pulse), .rebreak_req(rebreak_req), .busy(busy),
    .err(inj_err)
  );
endmodule

// File: rtl/dbg_inject_chk.sv
module dbg_inject_chk #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] NOP_BYTE = 8'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_pulse,
  input logic              rebreak_req,
  input logic              busy,
  input logic              inj_err,
  input logic              core_retire,
  input logic              dbg_err_clr,
  input logic              trig_wr,
  input logic              fetch_ovf,
  input logic [DATA_W-1:0] fetch_data
);
  p_step_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse);
  p_step_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> busy);
  p_trig_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && !busy) |=> (step_pulse && busy));
  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && busy) |=> (inj_err && !step_pulse));
  p_ovf_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ovf |-> (fetch_data == NOP_BYTE));
  p_ovf_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ovf |=> inj_err);
  p_rebreak_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rebreak_req |=> !rebreak_req);
  p_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && core_retire) |=> (rebreak_req && !busy));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_err && !dbg_err_clr) |=> inj_err);
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> (!step_pulse && !rebreak_req && !busy && !inj_err));
endmodule

bind dbg_inject_buf dbg_inject_chk #(.DATA_W(DATA_W), .NOP_BYTE(NOP_BYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_pulse(step_pulse), .rebreak_req(rebreak_req),
  .busy(busy), .inj_err(inj_err), .core_retire(core_retire),
  .dbg_err_clr(dbg_err_clr), .trig_wr(trig_wr), .fetch_ovf(fetch_ovf),
  .fetch_data(fetch_data)
);

// File: tb/dbg_inject_buf_test.sv
module dbg_inject_buf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_start = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00;
  logic       err_clr = 1'b0, retire = 1'b0, f_req = 1'b0;
  logic [2:0] f_idx = 3'd0;
  logic [7:0] f_data;
  logic       step, reb, busy, err;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dbg_inject_buf uut (
    .clk(clk), .rst_n(rst_n), .dbg_wr_en(wr_en), .dbg_wr_start(wr_start),
    .dbg_wr_addr(wr_addr), .dbg_wr_data(wr_data), .dbg_err_clr(err_clr),
    .core_retire(retire), .fetch_req(f_req), .fetch_idx(f_idx),
    .fetch_data(f_data), .step_pulse(step), .rebreak_req(reb),
    .busy(busy), .inj_err(err)
  );

  // Behavioural reference model: -1 marks an unwritten byte.
  int m_mem [5] = '{-1, -1, -1, -1, -1};
  int m_ptr = 0;
  bit m_step = 0, m_reb = 0, m_busy = 0, m_err = 0;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int a;
    bit n_step, n_reb, n_busy, n_err;
    if (!rst_n) begin
      m_ptr = 0; m_step = 0; m_reb = 0; m_busy = 0; m_err = 0;
    end else begin
      a = wr_start ? int'(wr_addr) : m_ptr;
      n_step = 0; n_reb = 0; n_busy = m_busy; n_err = m_err && !err_clr;
      if (wr_en) begin
        m_ptr = (a + 1) % 256;
        if (a >= 'h21 && a <= 'h25) begin
          if (a == 'h25) begin
            if (!m_busy) begin m_mem[0] = int'(wr_data); n_step = 1; n_busy = 1; end
            else n_err = 1;
          end else if (!m_busy) m_mem['h25 - a] = int'(wr_data);
        end
      end
      if (m_busy && retire) begin n_busy = 0; n_reb = 1; end
      if (f_req && m_busy && f_idx > 3'd4) n_err = 1;
      m_step = n_step; m_reb = n_reb; m_busy = n_busy; m_err = n_err;
    end
  end

  always @(posedge clk) begin
    #5;
    if (!done) begin
      chk("R3 step_pulse", step, m_step);
      chk("R3 busy", busy, m_busy);
      chk("R8 rebreak_req", reb, m_reb);
      chk("R9 inj_err", err, m_err);
      if (f_idx > 3'd4) chk("R7 fetch_data", f_data, 0);
      else if (m_mem[f_idx] >= 0) chk("R4 fetch_data", f_data, m_mem[f_idx]);
    end
  end

  task automatic wr(input bit st, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_start = st; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_start = 1'b0;
  endtask

  task automatic fetch(input int idx, input int exp, input string tag);
    @(negedge clk);
    f_req = 1'b1; f_idx = 3'(idx);
    #2 chk(tag, f_data, exp);
    @(negedge clk);
    f_req = 1'b0;
  endtask

  task automatic do_retire();
    @(negedge clk); retire = 1'b1;
    @(negedge clk); retire = 1'b0;
    #1;
    chk("R8 busy cleared", busy, 0);
    chk("R8 rebreak pulse", reb, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 step", step, 0); chk("R10 rebreak", reb, 0);
    chk("R10 busy", busy, 0); chk("R10 err", err, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 err after reset", err, 0);

    // Two-byte instruction: burst 24h (byte 1) then 25h (trigger).
    wr(1'b1, 8'h24, 8'hAB);
    wr(1'b0, 8'h00, 8'hCD);
    #1;
    chk("R3 step after trigger", step, 1);
    chk("R3 busy after trigger", busy, 1);
    @(negedge clk); #1;
    chk("R3 step one cycle", step, 0);
    fetch(0, 'hCD, "R4 byte0 first");
    fetch(1, 'hAB, "R4 byte1");
    do_retire();
    @(negedge clk); #1;
    chk("R8 rebreak one cycle", reb, 0);

    // Five-byte instruction: one ascending burst from 21h.
    wr(1'b1, 8'h21, 8'h11);
    wr(1'b0, 8'h00, 8'h22);
    wr(1'b0, 8'h00, 8'h33);
    wr(1'b0, 8'h00, 8'h44);
    wr(1'b0, 8'h00, 8'h55);
    fetch(0, 'h55, "R1 R2 byte0");
    fetch(1, 'h44, "R1 R2 byte1");
    fetch(2, 'h33, "R1 R2 byte2");
    fetch(3, 'h22, "R1 R2 byte3");
    fetch(4, 'h11, "R1 R2 byte4");

    // Operand write while busy is ignored.
    wr(1'b1, 8'h22, 8'h99);
    fetch(3, 'h22, "R5 byte3 unchanged");
    chk("R5 no error", err, 0);

    // Trigger while busy is rejected.
    wr(1'b1, 8'h25, 8'h77);
    #1;
    chk("R6 no step", step, 0);
    chk("R6 error set", err, 1);
    fetch(0, 'h55, "R6 byte0 unchanged");

    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0; #1;
    chk("R9 cleared", err, 0);

    // Over-long fetch while busy.
    fetch(5, 'h00, "R7 nop byte");
    #1;
    chk("R7 error set", err, 1);
    repeat (2) @(negedge clk);
    #1;
    chk("R9 sticky", err, 1);
    // Clear coinciding with a new error: error wins.
    @(negedge clk); err_clr = 1'b1; f_req = 1'b1; f_idx = 3'd6;
    @(negedge clk); err_clr = 1'b0; f_req = 1'b0; f_idx = 3'd0; #1;
    chk("R9 set wins", err, 1);
    do_retire();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;

    // Retire while idle does nothing.
    @(negedge clk); retire = 1'b1;
    @(negedge clk); retire = 1'b0; #1;
    chk("R8 idle retire", reb, 0);

    // Out-of-window writes ignored; burst from 20h carries into 21h.
    wr(1'b1, 8'h20, 8'hEE);
    wr(1'b0, 8'h00, 8'h5A);
    wr(1'b1, 8'h26, 8'hEF);
    wr(1'b1, 8'h25, 8'h3C);
    fetch(0, 'h3C, "R1 byte0 new");
    fetch(1, 'h44, "R1 byte1 kept");
    fetch(4, 'h5A, "R2 R1 byte4 via 21h");
    do_retire();

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule